// File: doc/BRIEF.md
# Two-Phase Disk Idle Power Timer

This block watches host I/O cycles and brings the hard disk down in two stages once the disk has gone unused. It counts tick pulses (nominally one per second) from the last access to the disk's command and control ports. When the selected idle period has passed, it first asks for the disk to spin down and for its interface to be disabled. A fixed ten-second grace period follows. After that, disk power is removed and the disk controller's clock is asked to stop.

Any further access to the disk ports cancels whichever phase is running and restarts the idle count. If the disk is already unpowered, that access also raises a one-cycle wake pulse, restores power and releases the clock stop. The reset pulse that the drive needs at power-up belongs to a companion sequencer and is not generated here.

Top module: `disk_idle_pwr_timer`

## Requirements
- R1: After reset, disk_pwr_en is 1 and standby_req, clk_stop_req and wake_req are 0, and the idle count starts from zero.
- R2: A qualifying access is a cycle with io_strobe high and a full 16-bit io_addr in 0x01F0..0x01F7 or equal to 0x03F6. Any other address, or any address with io_strobe low, has no effect on the outputs or on the count.
- R3: For tmo_sel codes 0 to 8, the idle period is 10*(code+1) seconds. Codes 9, 10, 11 and 12 give 120, 180, 240 and 300 seconds.
- R4: Code 13 gives 1800 seconds while ac_present is 1, and 300 seconds while it is 0. Codes 14 and 15 are reserved and give 300 seconds.
- R5: In the active phase, standby_req rises at the clock edge that samples the N-th tick since the last qualifying access or reset, where N is the idle period times TICKS_PER_SEC. It does not rise at any earlier edge.
- R6: In standby, disk_pwr_en falls and clk_stop_req rises at the edge that samples the 10th tick counted from entry to standby. standby_req stays high, and the block never moves from active straight to off.
- R7: A qualifying access in standby returns standby_req to 0 at the next edge and restarts the full first-phase count.
- R8: A qualifying access while the disk is off sets disk_pwr_en to 1 and clears clk_stop_req and standby_req at the next edge. It also raises wake_req for exactly one cycle. wake_req is never high otherwise.
- R9: Ticks are ignored while the disk is off. When a tick and a qualifying access fall in the same cycle, the access wins and the count restarts.
- R10: clk_stop_req is never high while disk_pwr_en is high or while standby_req is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle timebase pulse, nominally once per second |
| io_strobe | input | 1 | Host I/O cycle valid |
| io_addr | input | 16 | Host I/O address |
| tmo_sel | input | 4 | First-phase idle period select code |
| ac_present | input | 1 | External power present |
| standby_req | output | 1 | Spin down disk and disable its interface |
| disk_pwr_en | output | 1 | Disk power enable, active high |
| clk_stop_req | output | 1 | Request to stop the disk controller clock |
| wake_req | output | 1 | One-cycle pulse when an access wakes an unpowered disk |

## Verification
The bench uses the default TICKS_PER_SEC of 1 and PH2_SECS of 10 and drives the tick input as a fast pulse, often on every cycle. With these settings even the 1800-tick mains-only setting, and the battery fallback for codes 13 to 15, can be checked exactly at their expiry edge within a short run. The short codes expire within tens of cycles. This lets random access and tick patterns repeatedly cross both phases, the wake path, tick-and-access collisions, and near-miss addresses such as 0x01EF, 0x01F8, 0x03F7 and aliases that differ only in the upper address bits.

// File: rtl/dipt_pkg.sv
package dipt_pkg;

    typedef enum logic [1:0] {
        PH_ACTIVE  = 2'd0,
        PH_STANDBY = 2'd1,
        PH_OFF     = 2'd2
    } phase_e;

    localparam int unsigned LONGEST_SECS = 1800;
    localparam int unsigned BATT_MAX_SECS = 300;

    // First-phase idle period in seconds for a select code
    function automatic int unsigned idle_secs(input logic [3:0] sel, input logic ac);
        int unsigned s;
        if (sel <= 4'd8)
            s = 10 * (int'(sel) + 1);
        else if (sel <= 4'd12)
            s = 60 * (int'(sel) - 7);
        else if (sel == 4'd13 && ac)
            s = LONGEST_SECS;
        else
            s = BATT_MAX_SECS;
        return s;
    endfunction

endpackage

// File: rtl/dipt_addr_match.sv
module dipt_addr_match #(
    parameter logic [15:0] CMD_BASE = 16'h01F0,
    parameter int unsigned CMD_SPAN_LOG2 = 3,
    parameter logic [15:0] CTL_ADDR = 16'h03F6
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        io_strobe,
    input  logic [15:0] io_addr,
    output logic        hit
);

    localparam int unsigned TAG_W = 16 - CMD_SPAN_LOG2;

    logic cmd_hit;
    logic ctl_hit;

    always_comb begin
        cmd_hit = (io_addr[15:CMD_SPAN_LOG2] == CMD_BASE[15:CMD_SPAN_LOG2]);
        ctl_hit = (io_addr == CTL_ADDR);
        hit     = io_strobe && (cmd_hit || ctl_hit);
    end

    // R2
    strobe_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (io_strobe && (io_addr[15:TAG_W-TAG_W+CMD_SPAN_LOG2] != 13'h0000 || io_addr == CTL_ADDR)));

endmodule

// File: rtl/dipt_limit_sel.sv
module dipt_limit_sel
    import dipt_pkg::*;
#(
    parameter int unsigned TICKS_PER_SEC = 1,
    parameter int unsigned CNT_W = 11
) (
    input  logic [3:0]       tmo_sel,
    input  logic             ac_present,
    output logic [CNT_W-1:0] limit
);

    always_comb begin
        limit = CNT_W'(idle_secs(tmo_sel, ac_present) * TICKS_PER_SEC);
    end

endmodule

// File: rtl/dipt_tick_cnt.sv
module dipt_tick_cnt #(
    parameter int unsigned CNT_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    output logic [CNT_W-1:0] count
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr)
            cnt_d = '0;
        else if (inc)
            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else
            cnt_q <= cnt_d;
    end

    assign count = cnt_q;

    // R5
    no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !clr) |-> (cnt_q != '1));

endmodule

// File: rtl/disk_idle_pwr_timer.sv
module disk_idle_pwr_timer
    import dipt_pkg::*;
#(
    parameter int unsigned TICKS_PER_SEC = 1,
    parameter int unsigned PH2_SECS = 10
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tick,
    input  logic        io_strobe,
    input  logic [15:0] io_addr,
    input  logic [3:0]  tmo_sel,
    input  logic        ac_present,
    output logic        standby_req,
    output logic        disk_pwr_en,
    output logic        clk_stop_req,
    output logic        wake_req
);

    localparam int unsigned MAX_TICKS = LONGEST_SECS * TICKS_PER_SEC;
    localparam int unsigned CNT_W = $clog2(MAX_TICKS + 1);
    localparam logic [CNT_W:0] PH2_TICKS = (CNT_W+1)'(PH2_SECS * TICKS_PER_SEC);

    typedef struct packed {
        phase_e phase;
        logic   wake;
    } ctl_s;

    ctl_s ctl_d, ctl_q;

    logic             hit;
    logic [CNT_W-1:0] limit;
    logic [CNT_W-1:0] count;
    logic [CNT_W:0]   count_nx;
    logic             cnt_clr;
    logic             cnt_inc;

    dipt_addr_match u_match (
        .clk       (clk),
        .rst_n     (rst_n),
        .io_strobe (io_strobe),
        .io_addr   (io_addr),
        .hit       (hit)
    );

    dipt_limit_sel #(
        .TICKS_PER_SEC (TICKS_PER_SEC),
        .CNT_W         (CNT_W)
    ) u_limit (
        .tmo_sel    (tmo_sel),
        .ac_present (ac_present),
        .limit      (limit)
    );

    dipt_tick_cnt #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_clr),
        .inc   (cnt_inc),
        .count (count)
    );

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.wake = 1'b0;
        cnt_clr    = 1'b0;
        cnt_inc    = 1'b0;
        count_nx   = {1'b0, count} + 1'b1;
        if (hit) begin
            // access wins over any tick and restarts phase one
            ctl_d.phase = PH_ACTIVE;
            ctl_d.wake  = (ctl_q.phase == PH_OFF);
            cnt_clr     = 1'b1;
        end else if (tick) begin
            unique case (ctl_q.phase)
                PH_ACTIVE: begin
                    if (count_nx >= {1'b0, limit}) begin
                        ctl_d.phase = PH_STANDBY;
                        cnt_clr     = 1'b1;
                    end else begin
                        cnt_inc = 1'b1;
                    end
                end
                PH_STANDBY: begin
                    if (count_nx >= PH2_TICKS) begin
                        ctl_d.phase = PH_OFF;
                        cnt_clr     = 1'b1;
                    end else begin
                        cnt_inc = 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q.phase <= PH_ACTIVE;
            ctl_q.wake  <= 1'b0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign standby_req  = (ctl_q.phase != PH_ACTIVE);
    assign disk_pwr_en  = (ctl_q.phase != PH_OFF);
    assign clk_stop_req = (ctl_q.phase == PH_OFF);
    assign wake_req     = ctl_q.wake;

    // R10
    clkstop_pwr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clk_stop_req |-> (!disk_pwr_en && standby_req));

    // R7
    hit_rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> (!standby_req && disk_pwr_en));

    // R8
    wake_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wake_req |=> !wake_req);

    // R8
    wake_from_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wake_req) |-> $past(clk_stop_req));

    // R9
    off_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_stop_req && !hit) |=> clk_stop_req);

    // R6
    no_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !standby_req |=> !clk_stop_req);

    // R6
    ph2_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.phase == PH_STANDBY) |-> ({1'b0, count} < PH2_TICKS));

endmodule

// File: tb/disk_idle_pwr_timer_tb.sv
module disk_idle_pwr_timer_tb_top;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        tick;
    logic        io_strobe;
    logic [15:0] io_addr;
    logic [3:0]  tmo_sel;
    logic        ac_present;
    logic        standby_req;
    logic        disk_pwr_en;
    logic        clk_stop_req;
    logic        wake_req;

    int n_tests = 0;
    int n_fail  = 0;

    // bench reference state: 0 active, 1 standby, 2 off
    int m_ph   = 0;
    int m_cnt  = 0;
    bit m_wake = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    disk_idle_pwr_timer dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick         (tick),
        .io_strobe    (io_strobe),
        .io_addr      (io_addr),
        .tmo_sel      (tmo_sel),
        .ac_present   (ac_present),
        .standby_req  (standby_req),
        .disk_pwr_en  (disk_pwr_en),
        .clk_stop_req (clk_stop_req),
        .wake_req     (wake_req)
    );

    function automatic int exp_ticks(input logic [3:0] sel, input logic ac);
        if (sel <= 8) return 10 * (sel + 1);
        if (sel <= 12) return 60 * (sel - 7);
        if (sel == 13 && ac) return 1800;
        return 300;
    endfunction

    function automatic bit is_disk_port(input logic st, input logic [15:0] a);
        return st && ((a >= 16'h01F0 && a <= 16'h01F7) || a == 16'h03F6);
    endfunction

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic check_model(input string tag);
        chk(tag, "standby_req", standby_req, m_ph != 0);
        chk(tag, "disk_pwr_en", disk_pwr_en, m_ph != 2);
        chk(tag, "clk_stop_req", clk_stop_req, m_ph == 2);
        chk(tag, "wake_req", wake_req, m_wake);
    endtask

    // one cycle: drive at negedge, advance the model, sample at next negedge
    task automatic step(input logic st, input logic [15:0] a, input logic tk, input string tag);
        bit h;
        int nph, ncnt;
        bit nw;
        io_strobe = st;
        io_addr   = a;
        tick      = tk;
        h = is_disk_port(st, a);
        nph = m_ph; ncnt = m_cnt; nw = 1'b0;
        if (h) begin
            nph = 0; ncnt = 0; nw = (m_ph == 2);
        end else if (tk && m_ph == 0) begin
            if (m_cnt + 1 >= exp_ticks(tmo_sel, ac_present)) begin nph = 1; ncnt = 0; end
            else ncnt = m_cnt + 1;
        end else if (tk && m_ph == 1) begin
            if (m_cnt + 1 >= 10) begin nph = 2; ncnt = 0; end
            else ncnt = m_cnt + 1;
        end
        @(posedge clk);
        @(negedge clk);
        m_ph = nph; m_cnt = ncnt; m_wake = nw;
        check_model(tag);
    endtask

    task automatic run_ticks(input int n, input string tag);
        for (int i = 0; i < n; i++) step(1'b0, 16'h0000, 1'b1, tag);
    endtask

    // full walk through both phases and the wake path
    task automatic expire_walk(input logic [3:0] sel, input logic ac, input int n, input string tag);
        tmo_sel = sel; ac_present = ac;
        step(1'b1, 16'h01F0, 1'b0, tag);
        run_ticks(n - 1, tag);
        chk(tag, "standby before last tick", standby_req, 0);
        run_ticks(1, tag);
        chk(tag, "standby at expiry", standby_req, 1);
        run_ticks(9, "R6");
        chk("R6", "power held in phase two", disk_pwr_en, 1);
        run_ticks(1, "R6");
        chk("R6", "power removed", disk_pwr_en, 0);
        chk("R6", "clock stop", clk_stop_req, 1);
        run_ticks(5, "R9");
        chk("R9", "ticks ignored while off", clk_stop_req, 1);
        step(1'b1, 16'h03F6, 1'b1, "R8");
        chk("R8", "wake pulse", wake_req, 1);
        chk("R8", "power restored", disk_pwr_en, 1);
        chk("R8", "standby cleared", standby_req, 0);
        step(1'b0, 16'h0000, 1'b0, "R8");
        chk("R8", "wake pulse ends", wake_req, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [15:0] addrs [10];
        int seed;
        seed = 32'h5EED1234;
        void'($urandom(seed));
        addrs = '{16'h01F0, 16'h01F3, 16'h01F7, 16'h03F6, 16'h01EF,
                  16'h01F8, 16'h03F7, 16'h03F5, 16'h11F2, 16'h83F6};
        rst_n = 1'b0; tick = 1'b0; io_strobe = 1'b0; io_addr = '0;
        tmo_sel = 4'd0; ac_present = 1'b0;
        repeat (3) @(posedge clk);
        // ticks and hits during reset must not matter
        @(negedge clk);
        tick = 1'b1; io_strobe = 1'b1; io_addr = 16'h01F0;
        @(negedge clk);
        rst_n = 1'b1; tick = 1'b0; io_strobe = 1'b0;
        m_ph = 0; m_cnt = 0; m_wake = 0;
        // R1
        check_model("R1");

        // R1 count starts at zero: 10th tick after reset expires
        run_ticks(9, "R1");
        chk("R1", "no standby after 9 ticks", standby_req, 0);
        run_ticks(1, "R1");
        chk("R1", "standby after 10 ticks", standby_req, 1);

        // R3 / R5 short codes and a minute code
        expire_walk(4'd0, 1'b0, 10, "R5");
        expire_walk(4'd8, 1'b1, 90, "R3");
        expire_walk(4'd9, 1'b0, 120, "R3");
        expire_walk(4'd12, 1'b1, 300, "R3");
        // R4 long setting and fallbacks
        expire_walk(4'd13, 1'b1, 1800, "R4");
        expire_walk(4'd13, 1'b0, 300, "R4");
        expire_walk(4'd15, 1'b1, 300, "R4");

        // R2 near misses do not rearm the count
        tmo_sel = 4'd0; ac_present = 1'b0;
        step(1'b1, 16'h01F5, 1'b0, "R2");
        for (int i = 0; i < 9; i++) begin
            step(1'b1, addrs[4 + (i % 6)], 1'b1, "R2");
            step(1'b0, 16'h01F0, 1'b0, "R2");
        end
        chk("R2", "no standby before 10th tick", standby_req, 0);
        step(1'b0, 16'h01F0, 1'b1, "R2");
        chk("R2", "misses did not restart count", standby_req, 1);

        // R7 access in standby rearms full count
        run_ticks(4, "R7");
        step(1'b1, 16'h01F7, 1'b0, "R7");
        chk("R7", "standby cleared", standby_req, 0);
        run_ticks(9, "R7");
        chk("R7", "full count restarted", standby_req, 0);
        run_ticks(1, "R7");
        chk("R7", "re-expiry", standby_req, 1);

        // R9 tick and access together: access wins
        step(1'b1, 16'h01F1, 1'b0, "R9");
        run_ticks(9, "R9");
        step(1'b1, 16'h01F2, 1'b1, "R9");
        chk("R9", "collision keeps active", standby_req, 0);
        run_ticks(9, "R9");
        chk("R9", "count restarted by collision", standby_req, 0);

        // random mix, R10 consistency checked every cycle by the model
        for (int seg = 0; seg < 20; seg++) begin
            tmo_sel = 4'($urandom % 3);
            ac_present = 1'($urandom % 2);
            if (seg % 5 == 4) tmo_sel = 4'd13 + 4'($urandom % 3);
            for (int c = 0; c < 200; c++) begin
                bit st;
                st = ($urandom % 30) == 0;
                step(st, addrs[$urandom % 10], 1'(($urandom % 4) != 0), "R10");
            end
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule